// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the entry half of exception and interrupt handling for a small 32-bit processor core. The core presents one pending request together with its cause (hardware interrupt, break, non-maskable interrupt or bus fault), the current program counter, the delay-slot count, the status word, the stack pointer, the kernel stack pointer, the vector base and the version number. The block checks whether the request may be taken. If it may, it commits the new architectural state in one cycle: the saved return address, the exception-status word, the shifted status word and, when leaving user mode, the stack swap.

After that commit the block fetches the handler address. It issues a read of the vector table entry over a request/grant port and waits for the read response. The response becomes the new program counter, and a one-cycle done pulse marks the end of the entry. Until then the block reports busy and ignores further requests. Instruction decode, address translation and the interrupt controller are outside the block and appear only as input signals.

Top module: `exc_entry_seq`

## Requirements
- R1: A hardware interrupt (cause 0) is taken only when status bit 5 (interrupt enable) is 1 and `irq_locked` is 0; otherwise no commit occurs.
- R2: An NMI (cause 2) is taken only when its enable bit is 1: bit 7 of status when `version_in` < 32, bit 9 when `version_in` >= 32. Break (cause 1) and bus fault (cause 3) are always taken.
- R3: The vector is `trap_vec` for break, 0 for NMI, `fault_vec` for bus fault and `irq_vec` for an interrupt. The handler read address is `vbase_in + vector*4`.
- R4: The saved return address is `pc_in - dslot_in`. An NMI writes it to the NMI return register (`nrp_we`); every other cause writes it to the general return register (`erp_we`). `dslot_clr` pulses when `dslot_in` is nonzero.
- R5: `exs_out` holds the vector in bits 15:8, and all other bits are zero.
- R6: For an NMI, the selected enable bit is cleared first. The new status then keeps bits 31:30, places old bits 19:0 at 29:10 and clears bits 9:0.
- R7: When status bit 6 (user mode) is set, `usp_out` takes `sp_in`, `sp_out` takes `ksp_in` and `usp_we` pulses. Otherwise `usp_we` stays 0.
- R8: All commit outputs and the `commit` pulse appear in the cycle after the request is taken, and `busy` rises at the same edge.
- R9: `rd_req` stays high with a stable `rd_addr` until `rd_gnt`. The first `rd_rvalid` after the grant loads `pc_out` from `rd_rdata`, pulses `done` and clears `busy`.
- R10: A request presented while `busy` is high produces no commit and does not change `rd_addr`.
- R11: After reset, `busy`, `commit`, `done`, `rd_req` and `pc_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception or interrupt pending |
| cause | input | 2 | 0 interrupt, 1 break, 2 NMI, 3 bus fault |
| pc_in | input | 32 | Current program counter |
| dslot_in | input | DSLOT_W | Delay-slot count (0 when not in a slot) |
| status_in | input | 32 | Current status word |
| version_in | input | 8 | Core version number |
| irq_locked | input | 1 | Interrupt lock active |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack pointer |
| vbase_in | input | 32 | Vector table base |
| trap_vec | input | 8 | Vector for a break |
| irq_vec | input | 8 | Vector from the interrupt controller |
| fault_vec | input | 8 | Vector latched by address translation |
| busy | output | 1 | Entry in progress |
| commit | output | 1 | One-cycle pulse: commit outputs valid |
| erp_we | output | 1 | Write general return register |
| nrp_we | output | 1 | Write NMI return register |
| ret_addr | output | 32 | Return address to save |
| exs_out | output | 32 | Exception-status word |
| status_out | output | 32 | New status word |
| usp_we | output | 1 | Write user stack pointer and stack pointer |
| usp_out | output | 32 | Saved user stack pointer |
| sp_out | output | 32 | New stack pointer |
| dslot_clr | output | 1 | Clear delay-slot state |
| rd_req | output | 1 | Handler read request |
| rd_addr | output | 32 | Handler read address |
| rd_gnt | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle pulse: pc_out loaded |
| pc_out | output | 32 | Handler address (new program counter) |

## Verification
A delay-slot rewind and a stack swap can commit in the same cycle. So can an NMI's enable-bit clearing and the status shift. The bench provokes the first by taking a break and a bus fault from user mode with a nonzero delay-slot count, and the second by taking NMIs under both version ranges. Each commit is judged against return-address, stack and status values that the bench computes from the requirements.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN      = 32;
    localparam int VEC_W     = 8;
    localparam int VER_W     = 8;
    localparam int IE_BIT    = 5;
    localparam int USER_BIT  = 6;
    localparam int NMI_EN_LO = 7;   // used when version < VER_SPLIT
    localparam int NMI_EN_HI = 9;   // used when version >= VER_SPLIT
    localparam int VER_SPLIT = 32;
    localparam int KEEP_HI   = 2;   // top status bits kept in place
    localparam int STACK_SH  = 10;  // status shift distance

    typedef enum logic [1:0] {
        CAUSE_IRQ   = 2'd0,
        CAUSE_BREAK = 2'd1,
        CAUSE_NMI   = 2'd2,
        CAUSE_BUS   = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [XLEN-1:0] ret_addr;
        logic            to_nrp;
        logic [XLEN-1:0] exs;
        logic [XLEN-1:0] status;
        logic            swap;
        logic [XLEN-1:0] handler_addr;
    } frame_t;

    // Keep the top bits, move the low field up, clear the vacated bits.
    function automatic logic [XLEN-1:0] stack_status(input logic [XLEN-1:0] s);
        return {s[XLEN-1 -: KEEP_HI], s[XLEN-KEEP_HI-STACK_SH-1:0], {STACK_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/exc_accept.sv
module exc_accept
    import exc_entry_pkg::*;
(
    input  logic             req_valid,
    input  cause_e           cause,
    input  logic [XLEN-1:0]  status,
    input  logic [VER_W-1:0] version,
    input  logic             irq_locked,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic [VEC_W-1:0] fault_vec,
    output logic             take,
    output logic [VEC_W-1:0] vec,
    output logic [XLEN-1:0]  nmi_mask
);
    logic nmi_en;

    always_comb begin
        nmi_mask = '0;
        if (version < VER_W'(VER_SPLIT)) nmi_mask[NMI_EN_LO] = 1'b1;
        else                             nmi_mask[NMI_EN_HI] = 1'b1;
        nmi_en = |(status & nmi_mask);
    end

    always_comb begin
        take = 1'b0;
        vec  = '0;
        unique case (cause)
            CAUSE_IRQ: begin
                take = req_valid && status[IE_BIT] && !irq_locked;
                vec  = irq_vec;
            end
            CAUSE_BREAK: begin
                take = req_valid;
                vec  = trap_vec;
            end
            CAUSE_NMI: begin
                take = req_valid && nmi_en;
                vec  = '0;
            end
            CAUSE_BUS: begin
                take = req_valid;
                vec  = fault_vec;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_frame.sv
module exc_frame
    import exc_entry_pkg::*;
#(
    parameter int DSLOT_W = 2
) (
    input  cause_e             cause,
    input  logic [VEC_W-1:0]   vec,
    input  logic [XLEN-1:0]    nmi_mask,
    input  logic [XLEN-1:0]    pc,
    input  logic [DSLOT_W-1:0] dslot,
    input  logic [XLEN-1:0]    status,
    input  logic [XLEN-1:0]    vbase,
    output frame_t             frame
);
    localparam int EXS_LO = 8;
    logic [XLEN-1:0] masked;

    always_comb begin
        masked             = (cause == CAUSE_NMI) ? (status & ~nmi_mask) : status;
        frame.ret_addr     = pc - XLEN'(dslot);
        frame.to_nrp       = (cause == CAUSE_NMI);
        frame.exs          = '0;
        frame.exs[EXS_LO +: VEC_W] = vec;
        frame.status       = stack_status(masked);
        frame.swap         = status[USER_BIT];
        frame.handler_addr = vbase + (XLEN'(vec) << 2);
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int DSLOT_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         cause,
    input  logic [31:0]        pc_in,
    input  logic [DSLOT_W-1:0] dslot_in,
    input  logic [31:0]        status_in,
    input  logic [7:0]         version_in,
    input  logic               irq_locked,
    input  logic [31:0]        sp_in,
    input  logic [31:0]        ksp_in,
    input  logic [31:0]        vbase_in,
    input  logic [7:0]         trap_vec,
    input  logic [7:0]         irq_vec,
    input  logic [7:0]         fault_vec,
    output logic               busy,
    output logic               commit,
    output logic               erp_we,
    output logic               nrp_we,
    output logic [31:0]        ret_addr,
    output logic [31:0]        exs_out,
    output logic [31:0]        status_out,
    output logic               usp_we,
    output logic [31:0]        usp_out,
    output logic [31:0]        sp_out,
    output logic               dslot_clr,
    output logic               rd_req,
    output logic [31:0]        rd_addr,
    input  logic               rd_gnt,
    input  logic               rd_rvalid,
    input  logic [31:0]        rd_rdata,
    output logic               done,
    output logic [31:0]        pc_out
);
    seq_state_e       state_q;
    logic             take;
    logic [VEC_W-1:0] vec;
    logic [XLEN-1:0]  nmi_mask;
    frame_t           frame;
    cause_e           cause_t;

    assign cause_t = cause_e'(cause);

    exc_accept u_accept (
        .req_valid  (req_valid),
        .cause      (cause_t),
        .status     (status_in),
        .version    (version_in),
        .irq_locked (irq_locked),
        .trap_vec   (trap_vec),
        .irq_vec    (irq_vec),
        .fault_vec  (fault_vec),
        .take       (take),
        .vec        (vec),
        .nmi_mask   (nmi_mask)
    );

    exc_frame #(.DSLOT_W(DSLOT_W)) u_frame (
        .cause    (cause_t),
        .vec      (vec),
        .nmi_mask (nmi_mask),
        .pc       (pc_in),
        .dslot    (dslot_in),
        .status   (status_in),
        .vbase    (vbase_in),
        .frame    (frame)
    );

    assign busy   = (state_q != ST_IDLE);
    assign rd_req = (state_q == ST_REQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            commit     <= 1'b0;
            erp_we     <= 1'b0;
            nrp_we     <= 1'b0;
            usp_we     <= 1'b0;
            dslot_clr  <= 1'b0;
            done       <= 1'b0;
            ret_addr   <= '0;
            exs_out    <= '0;
            status_out <= '0;
            usp_out    <= '0;
            sp_out     <= '0;
            rd_addr    <= '0;
            pc_out     <= '0;
        end else begin
            commit    <= 1'b0;
            erp_we    <= 1'b0;
            nrp_we    <= 1'b0;
            usp_we    <= 1'b0;
            dslot_clr <= 1'b0;
            done      <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (take) begin
                    commit     <= 1'b1;
                    erp_we     <= !frame.to_nrp;
                    nrp_we     <= frame.to_nrp;
                    ret_addr   <= frame.ret_addr;
                    exs_out    <= frame.exs;
                    status_out <= frame.status;
                    usp_we     <= frame.swap;
                    dslot_clr  <= (dslot_in != '0);
                    rd_addr    <= frame.handler_addr;
                    if (frame.swap) begin
                        usp_out <= sp_in;
                        sp_out  <= ksp_in;
                    end
                    state_q <= ST_REQ;
                end
                ST_REQ:  if (rd_gnt) state_q <= ST_WAIT;
                ST_WAIT: if (rd_rvalid) begin
                    pc_out  <= rd_rdata;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10
    commit_only_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> !$past(busy));
    // R4
    one_return_target_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> $countones({erp_we, nrp_we}) == 1);
    // R6
    status_low_clear_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> status_out[9:0] == 10'd0);
    // R7
    stack_swap_chk: assert property (@(posedge clk) disable iff (rst)
        usp_we |-> (sp_out == $past(ksp_in)) && (usp_out == $past(sp_in)));
    // R9
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr)));
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  cause = '0;
    logic [31:0] pc_in = '0;
    logic [1:0]  dslot_in = '0;
    logic [31:0] status_in = '0;
    logic [7:0]  version_in = '0;
    logic        irq_locked = 1'b0;
    logic [31:0] sp_in = 32'h1000_0100;
    logic [31:0] ksp_in = 32'h2000_0200;
    logic [31:0] vbase_in = 32'h0000_4000;
    logic [7:0]  trap_vec = 8'h21;
    logic [7:0]  irq_vec = 8'h44;
    logic [7:0]  fault_vec = 8'h9C;
    logic        rd_gnt = 1'b0, rd_rvalid = 1'b0;
    logic [31:0] rd_rdata = '0;
    logic        busy, commit, erp_we, nrp_we, usp_we, dslot_clr, rd_req, done;
    logic [31:0] ret_addr, exs_out, status_out, usp_out, sp_out, rd_addr, pc_out;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    exc_entry_seq #(.DSLOT_W(2)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .cause(cause), .pc_in(pc_in),
        .dslot_in(dslot_in), .status_in(status_in), .version_in(version_in),
        .irq_locked(irq_locked), .sp_in(sp_in), .ksp_in(ksp_in), .vbase_in(vbase_in),
        .trap_vec(trap_vec), .irq_vec(irq_vec), .fault_vec(fault_vec), .busy(busy),
        .commit(commit), .erp_we(erp_we), .nrp_we(nrp_we), .ret_addr(ret_addr),
        .exs_out(exs_out), .status_out(status_out), .usp_we(usp_we), .usp_out(usp_out),
        .sp_out(sp_out), .dslot_clr(dslot_clr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_gnt(rd_gnt), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .done(done),
        .pc_out(pc_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Fields: cause, pc, dslot, status, version, locked
    typedef struct packed {
        logic [1:0]  cz;
        logic [31:0] pc;
        logic [1:0]  ds;
        logic [31:0] st;
        logic [7:0]  ver;
        logic        lk;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TABLE [NV] = '{
        '{2'd0, 32'h0000_1000, 2'd0, 32'h0000_0020, 8'd40, 1'b0}, // irq taken
        '{2'd0, 32'h0000_1004, 2'd0, 32'h0000_0020, 8'd40, 1'b1}, // irq locked
        '{2'd0, 32'h0000_1008, 2'd0, 32'h0000_0000, 8'd40, 1'b0}, // irq disabled
        '{2'd1, 32'h0000_2000, 2'd2, 32'hC00A_5A40, 8'd40, 1'b0}, // break, slot, user
        '{2'd2, 32'h0000_3000, 2'd0, 32'h0001_0380, 8'd10, 1'b0}, // nmi low version
        '{2'd2, 32'h0000_3004, 2'd0, 32'h0000_0200, 8'd10, 1'b0}, // nmi wrong bit
        '{2'd2, 32'h0000_3008, 2'd1, 32'h8000_0380, 8'd40, 1'b0}, // nmi high version
        '{2'd3, 32'h0000_4000, 2'd1, 32'h4FFF_FFFF, 8'd32, 1'b0}, // bus fault, user
        '{2'd2, 32'h0000_300C, 2'd0, 32'h0000_0080, 8'd32, 1'b0}  // nmi wrong bit hi
    };

    function automatic logic [31:0] nmi_bit(input logic [7:0] ver);
        return (ver < 8'd32) ? 32'h0000_0080 : 32'h0000_0200;
    endfunction

    function automatic logic exp_take(input vec_t v);
        case (v.cz)
            2'd0:    return v.st[5] && !v.lk;
            2'd2:    return (v.st & nmi_bit(v.ver)) != 0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_vec(input logic [1:0] cz);
        case (cz)
            2'd0:    return 8'h44;
            2'd1:    return 8'h21;
            2'd2:    return 8'h00;
            default: return 8'h9C;
        endcase
    endfunction

    function automatic logic [31:0] exp_status(input vec_t v);
        logic [31:0] s;
        s = v.st;
        if (v.cz == 2'd2) s = s & ~nmi_bit(v.ver);
        return {s[31:30], s[19:0], 10'd0};
    endfunction

    task automatic run_one(input vec_t v, input int idx);
        logic [31:0] haddr;
        cause = v.cz; pc_in = v.pc; dslot_in = v.ds; status_in = v.st;
        version_in = v.ver; irq_locked = v.lk; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 commit", {31'd0, commit}, {31'd0, exp_take(v)});
        if (!exp_take(v)) begin
            check((v.cz == 2'd0) ? "R1 rejected busy" : "R2 rejected busy", {31'd0, busy}, 32'd0);
            @(negedge clk);
            return;
        end
        haddr = 32'h0000_4000 + {22'd0, exp_vec(v.cz), 2'b00};
        check("R8 busy", {31'd0, busy}, 32'd1);
        check("R4 ret_addr", ret_addr, v.pc - {30'd0, v.ds});
        check("R4 erp_we", {31'd0, erp_we}, {31'd0, v.cz != 2'd2});
        check("R4 nrp_we", {31'd0, nrp_we}, {31'd0, v.cz == 2'd2});
        check("R4 dslot_clr", {31'd0, dslot_clr}, {31'd0, v.ds != 2'd0});
        check("R5 exs", exs_out, {16'd0, exp_vec(v.cz), 8'd0});
        check("R6 status", status_out, exp_status(v));
        check("R7 usp_we", {31'd0, usp_we}, {31'd0, v.st[6]});
        if (v.st[6]) begin
            check("R7 usp", usp_out, 32'h1000_0100);
            check("R7 sp", sp_out, 32'h2000_0200);
        end
        check("R3 rd_addr", rd_addr, haddr);
        check("R9 rd_req", {31'd0, rd_req}, 32'd1);
        @(negedge clk);                      // stall one cycle without grant
        check("R9 rd_req held", {31'd0, rd_req}, 32'd1);
        check("R9 rd_addr held", rd_addr, haddr);
        check("R8 commit pulse", {31'd0, commit}, 32'd0);
        rd_gnt = 1'b1;
        @(negedge clk);
        rd_gnt = 1'b0;
        check("R9 rd_req dropped", {31'd0, rd_req}, 32'd0);
        rd_rvalid = 1'b1; rd_rdata = haddr ^ 32'h1357_9BDF ^ idx;
        @(negedge clk);
        rd_rvalid = 1'b0;
        check("R9 done", {31'd0, done}, 32'd1);
        check("R9 pc_out", pc_out, haddr ^ 32'h1357_9BDF ^ idx);
        check("R9 busy clear", {31'd0, busy}, 32'd0);
        @(negedge clk);
        check("R9 done pulse", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check("R11 busy", {31'd0, busy}, 32'd0);
        check("R11 commit", {31'd0, commit}, 32'd0);
        check("R11 done", {31'd0, done}, 32'd0);
        check("R11 rd_req", {31'd0, rd_req}, 32'd0);
        check("R11 pc_out", pc_out, 32'd0);

        for (int i = 0; i < NV; i++) run_one(TABLE[i], i);

        // R10: a request while busy is ignored
        cause = 2'd1; pc_in = 32'h0000_5000; dslot_in = 2'd0; status_in = 32'h0;
        req_valid = 1'b1;
        @(negedge clk);
        check("R10 first commit", {31'd0, commit}, 32'd1);
        cause = 2'd3; pc_in = 32'h0000_6000;      // still valid, now busy
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 no second commit", {31'd0, commit}, 32'd0);
        check("R10 rd_addr unchanged", rd_addr, 32'h0000_4084);
        rd_gnt = 1'b1;
        @(negedge clk);
        rd_gnt = 1'b0; rd_rvalid = 1'b1; rd_rdata = 32'hCAFE_0001;
        @(negedge clk);
        rd_rvalid = 1'b0;
        check("R10 pc_out from first", pc_out, 32'hCAFE_0001);
        check("R10 ret_addr kept", ret_addr, 32'h0000_5000);
        @(negedge clk);
        check("R10 idle after", {31'd0, busy}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule